// File: doc/BRIEF.md
# ROM-Driven Accumulator Sequencer

This block walks a pointer through an external synchronous read-only memory and treats every fetched word as a small command. Each word holds a 16-bit operand and a 2-bit action code. The action either replaces an internal accumulator, adds a signed value to it, shifts it by a signed amount, or redirects the pointer to a new address. The accumulator drives the block's data output, so a program stored in the memory becomes a sequence of output patterns.

The memory registers its address on the clock edge, so the word seen by the block always belongs to the address it presented one cycle earlier. The block tracks this latency with a one-bit valid flag. The flag stays clear for the first cycle after reset, and for the cycle that follows a jump. In those cycles the word on the input belongs to a stale or abandoned address and is not executed.

Top module: `seq_accum_sequencer`

## Requirements
- R1: `rst` is asynchronous and active high. While it is high, `rom_addr` and `acc_out` read zero. In the first cycle after release, the word on `rom_word` is not executed, so `acc_out` stays zero across that edge.
- R2: When the word being executed is not a jump, `rom_addr` increases by one on every clock edge. It wraps from 2^AW-1 to 0.
- R3: The memory returns the word for the address presented on the previous cycle. Bits [17:16] of `rom_word` hold the action code and bits [15:0] hold the operand. The word fetched from address a is executed on the second edge after `rom_addr` showed a.
- R4: Action code 00 loads the operand into the accumulator, and `acc_out` shows it after that edge.
- R5: Action code 01 adds the operand, taken as a two's-complement value, to the accumulator. The sum wraps modulo 2^16.
- R6: Action code 10 with a positive operand n shifts the accumulator left by n, filling with zeros. An operand of 0 leaves it unchanged.
- R7: Action code 10 with a negative operand -n shifts the accumulator right logically by n, filling with zeros.
- R8: Action code 10 with a shift magnitude of 16 or more, in either direction, gives zero. This includes the operand 0x8000.
- R9: Action code 11 loads the pointer with the low AW bits of the operand. The accumulator and `acc_out` do not change.
- R10: After a jump, the word that arrives next belongs to the sequential address. It is discarded: `acc_out` does not change across that cycle, and the pointer moves to the jump target plus one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Asynchronous active-high reset |
| rom_addr | output | AW (8) | Pointer presented to the memory address register |
| rom_word | input | DW+2 (18) | Fetched word: action code in the top two bits, operand below |
| acc_out | output | DW (16) | Accumulator value after the most recent action |

## Verification
The bench builds the block with its defaults: an 8-bit pointer and a 16-bit accumulator. With the 8-bit pointer, a single jump to 0xFE reaches the pointer wrap, while the whole 256-word memory stays small enough to fill from the bench. With the 16-bit width, the shift limits can be reached directly: 15, 16, -16, 0x7FFF and 0x8000. Two jumps each leave a trap word at the sequential address. A mid-run reset places a load word at address 0 while the valid flag is still clear, which separates correct start-up latency from executing too early.

// File: rtl/seq_acc_pkg.sv
package seq_acc_pkg;

   localparam int CODE_W = 2;

   typedef enum logic [CODE_W-1:0] {
      ACT_LOAD  = 2'b00,
      ACT_ADD   = 2'b01,
      ACT_SHIFT = 2'b10,
      ACT_JUMP  = 2'b11
   } act_e;

endpackage

// File: rtl/seq_ptr.sv
module seq_ptr #(
   parameter int AW = 8,
   parameter int DW = 16
) (
   input  logic          clk,
   input  logic          rst,
   input  logic          take_jump,
   input  logic [DW-1:0] jump_target,
   output logic [AW-1:0] ptr,
   output logic          word_vld
);

   logic [AW-1:0] tgt;

   // the jump target is either cut down or widened to the pointer width
   generate
      if (AW <= DW) begin : g_trunc
         assign tgt = jump_target[AW-1:0];
      end else begin : g_zext
         assign tgt = {{(AW-DW){1'b0}}, jump_target};
      end
   endgenerate

   always_ff @(posedge clk or posedge rst) begin
      if (rst) begin
         ptr      <= '0;
         word_vld <= 1'b0;
      end else begin
         ptr      <= take_jump ? tgt : ptr + AW'(1);
         word_vld <= ~take_jump;
      end
   end

endmodule

// File: rtl/seq_shift.sv
module seq_shift #(
   parameter int DW = 16
) (
   input  logic [DW-1:0] din,
   input  logic [DW-1:0] amt,
   output logic [DW-1:0] dout
);

   localparam int SHW = $clog2(DW);

   logic          go_right;
   logic [DW-1:0] mag;
   logic          too_far;

   assign go_right = amt[DW-1];
   assign mag      = go_right ? (~amt + DW'(1)) : amt;

   // with a power-of-two width the range test is an OR of the upper bits
   generate
      if ((1 << SHW) == DW) begin : g_pow2
         assign too_far = |mag[DW-1:SHW];
      end else begin : g_cmp
         assign too_far = (mag >= DW[DW-1:0]);
      end
   endgenerate

   always_comb begin
      if (too_far)       dout = '0;
      else if (go_right) dout = din >> mag;
      else               dout = din << mag;
   end

endmodule

// File: rtl/seq_alu.sv
module seq_alu
   import seq_acc_pkg::*;
#(
   parameter int DW = 16
) (
   input  act_e          act,
   input  logic [DW-1:0] acc,
   input  logic [DW-1:0] opnd,
   output logic [DW-1:0] nxt
);

   logic [DW-1:0] shifted;

   seq_shift #(.DW(DW)) u_shift (
      .din  (acc),
      .amt  (opnd),
      .dout (shifted)
   );

   always_comb begin
      unique case (act)
         ACT_LOAD:  nxt = opnd;
         ACT_ADD:   nxt = acc + opnd;
         ACT_SHIFT: nxt = shifted;
         default:   nxt = acc;
      endcase
   end

endmodule

// File: rtl/seq_accum_sequencer.sv
module seq_accum_sequencer
   import seq_acc_pkg::*;
#(
   parameter int AW = 8,
   parameter int DW = 16
) (
   input  logic               clk,
   input  logic               rst,
   output logic [AW-1:0]      rom_addr,
   input  logic [DW+CODE_W-1:0] rom_word,
   output logic [DW-1:0]      acc_out
);

   initial begin
      assert (AW >= 1) else $error("seq_accum_sequencer: AW must be at least 1");
      assert (DW >= 2) else $error("seq_accum_sequencer: DW must be at least 2");
   end

   act_e          act;
   logic [DW-1:0] opnd;
   logic          word_vld;
   logic          take_jump;
   logic [DW-1:0] acc_q;
   logic [DW-1:0] acc_nxt;

   assign act       = act_e'(rom_word[DW+CODE_W-1:DW]);
   assign opnd      = rom_word[DW-1:0];
   assign take_jump = word_vld && (act == ACT_JUMP);

   seq_ptr #(.AW(AW), .DW(DW)) u_ptr (
      .clk         (clk),
      .rst         (rst),
      .take_jump   (take_jump),
      .jump_target (opnd),
      .ptr         (rom_addr),
      .word_vld    (word_vld)
   );

   seq_alu #(.DW(DW)) u_alu (
      .act  (act),
      .acc  (acc_q),
      .opnd (opnd),
      .nxt  (acc_nxt)
   );

   always_ff @(posedge clk or posedge rst) begin
      if (rst)           acc_q <= '0;
      else if (word_vld) acc_q <= acc_nxt;
   end

   assign acc_out = acc_q;

endmodule

// File: rtl/seq_accum_sequencer_chk.sv
module seq_accum_sequencer_chk #(
   parameter int AW = 8,
   parameter int DW = 16
) (
   input logic          clk,
   input logic          rst,
   input logic [AW-1:0] rom_addr,
   input logic [DW+1:0] rom_word,
   input logic [DW-1:0] acc_out,
   input logic          word_vld
);

   logic is_jump, is_load, is_add, is_nop_shift;

   assign is_jump      = word_vld && (rom_word[DW+1:DW] == 2'b11);
   assign is_load      = word_vld && (rom_word[DW+1:DW] == 2'b00);
   assign is_add       = word_vld && (rom_word[DW+1:DW] == 2'b01);
   assign is_nop_shift = word_vld && (rom_word[DW+1:DW] == 2'b10) && (rom_word[DW-1:0] == '0);

   // R1
   idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
      !word_vld |=> $stable(acc_out));

   // R2
   ptr_step_chk: assert property (@(posedge clk) disable iff (rst)
      !is_jump |=> rom_addr == $past(rom_addr) + AW'(1));

   // R9
   jump_target_chk: assert property (@(posedge clk) disable iff (rst)
      is_jump |=> rom_addr == AW'($past(rom_word[DW-1:0])));

   // R9
   jump_keeps_acc_chk: assert property (@(posedge clk) disable iff (rst)
      is_jump |=> $stable(acc_out));

   // R10
   jump_squash_chk: assert property (@(posedge clk) disable iff (rst)
      is_jump |=> !word_vld);

   // R4
   load_value_chk: assert property (@(posedge clk) disable iff (rst)
      is_load |=> acc_out == $past(rom_word[DW-1:0]));

   // R5
   add_wrap_chk: assert property (@(posedge clk) disable iff (rst)
      is_add |=> acc_out == DW'($past(acc_out) + $past(rom_word[DW-1:0])));

   // R6
   zero_shift_chk: assert property (@(posedge clk) disable iff (rst)
      is_nop_shift |=> $stable(acc_out));

endmodule

bind seq_accum_sequencer seq_accum_sequencer_chk #(.AW(AW), .DW(DW)) u_chk (
   .clk      (clk),
   .rst      (rst),
   .rom_addr (rom_addr),
   .rom_word (rom_word),
   .acc_out  (acc_out),
   .word_vld (word_vld)
);

// File: tb/tb_seq_accum_sequencer.sv
`timescale 1ns/1ps
module tb_seq_accum_sequencer;

   localparam int AW = 8;
   localparam int DW = 16;
   localparam int NV = 27;

   logic          clk = 1'b0;
   logic          rst = 1'b1;
   logic [AW-1:0] rom_addr;
   logic [DW+1:0] rom_word;
   logic [DW-1:0] acc_out;

   always #4 clk = ~clk;

   // behavioural memory with a registered address
   logic [DW+1:0] rom_mem [0:(1<<AW)-1];
   logic [AW-1:0] rom_q = '0;
   always_ff @(posedge clk) rom_q <= rom_addr;
   assign rom_word = rom_mem[rom_q];

   seq_accum_sequencer #(.AW(AW), .DW(DW)) dut (
      .clk      (clk),
      .rst      (rst),
      .rom_addr (rom_addr),
      .rom_word (rom_word),
      .acc_out  (acc_out)
   );

   // {squashed, address, code, operand, expected acc, expected pointer}
   // one row per clock cycle after the first one following reset release
   localparam logic [50:0] VEC [NV] = '{
      {1'b0, 8'h00, 2'd0, 16'h1234, 16'h1234, 8'h02},
      {1'b0, 8'h01, 2'd1, 16'h0001, 16'h1235, 8'h03},
      {1'b0, 8'h02, 2'd1, 16'hFFFF, 16'h1234, 8'h04},
      {1'b0, 8'h03, 2'd2, 16'h0004, 16'h2340, 8'h05},
      {1'b0, 8'h04, 2'd2, 16'hFFF8, 16'h0023, 8'h06},
      {1'b0, 8'h05, 2'd1, 16'h7FFF, 16'h8022, 8'h07},
      {1'b0, 8'h06, 2'd2, 16'hFFFF, 16'h4011, 8'h08},
      {1'b0, 8'h07, 2'd2, 16'h0000, 16'h4011, 8'h09},
      {1'b0, 8'h08, 2'd0, 16'hFFFF, 16'hFFFF, 8'h0A},
      {1'b0, 8'h09, 2'd1, 16'h0002, 16'h0001, 8'h0B},
      {1'b0, 8'h0A, 2'd2, 16'h000F, 16'h8000, 8'h0C},
      {1'b0, 8'h0B, 2'd2, 16'h0010, 16'h0000, 8'h0D},
      {1'b0, 8'h0C, 2'd0, 16'hA5A5, 16'hA5A5, 8'h0E},
      {1'b0, 8'h0D, 2'd2, 16'hFFF0, 16'h0000, 8'h0F},
      {1'b0, 8'h0E, 2'd0, 16'h00FF, 16'h00FF, 8'h10},
      {1'b0, 8'h0F, 2'd2, 16'h8000, 16'h0000, 8'h11},
      {1'b0, 8'h10, 2'd0, 16'h0F0F, 16'h0F0F, 8'h12},
      {1'b0, 8'h11, 2'd2, 16'h7FFF, 16'h0000, 8'h13},
      {1'b0, 8'h12, 2'd0, 16'hC003, 16'hC003, 8'h14},
      {1'b0, 8'h13, 2'd2, 16'hFFFF, 16'h6001, 8'h15},
      {1'b0, 8'h14, 2'd3, 16'h0040, 16'h6001, 8'h40},
      {1'b1, 8'h15, 2'd0, 16'hDEAD, 16'h6001, 8'h41},
      {1'b0, 8'h40, 2'd1, 16'h0001, 16'h6002, 8'h42},
      {1'b0, 8'h41, 2'd3, 16'h00FE, 16'h6002, 8'hFE},
      {1'b1, 8'h42, 2'd0, 16'hBAD0, 16'h6002, 8'hFF},
      {1'b0, 8'hFE, 2'd1, 16'h000E, 16'h6010, 8'h00},
      {1'b0, 8'hFF, 2'd0, 16'h0055, 16'h0055, 8'h01}
   };

   int n_chk = 0;
   int n_bad = 0;
   bit done  = 1'b0;

   task automatic check(input string tag, input string what, input int act, input int exp);
      n_chk++;
      if (act != exp) begin
         n_bad++;
         $display("FAIL %s %s: actual 0x%0h expected 0x%0h", tag, what, act, exp);
      end
   endtask

   task automatic report();
      if (!done) begin
         done = 1'b1;
         $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      end
   endtask

   function automatic string tag_of(input logic squashed, input logic [1:0] code);
      if (squashed) return "R10";
      case (code)
         2'd0:    return "R4";
         2'd1:    return "R5";
         2'd2:    return "R6 R7 R8";
         default: return "R9";
      endcase
   endfunction

   initial begin
      #(8 * 5000);
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      report();
      $finish;
   end

   initial begin
      for (int a = 0; a < (1 << AW); a++) rom_mem[a] = '0;
      for (int i = 0; i < NV; i++) rom_mem[VEC[i][49:42]] = VEC[i][41:24];

      // R1: reset state
      repeat (3) @(posedge clk);
      @(negedge clk);
      check("R1", "acc in reset", int'(acc_out), 0);
      check("R1", "addr in reset", int'(rom_addr), 0);

      rst = 1'b0;
      @(negedge clk);
      check("R1", "acc first cycle", int'(acc_out), 0);
      check("R2", "addr first cycle", int'(rom_addr), 1);

      // program walk, one row per cycle
      for (int i = 0; i < NV; i++) begin
         @(negedge clk);
         check(tag_of(VEC[i][50], VEC[i][41:40]), "acc", int'(acc_out), int'(VEC[i][23:8]));
         check("R2 R3", "addr", int'(rom_addr), int'(VEC[i][7:0]));
      end

      // R1: asynchronous reset between edges
      @(negedge clk);
      #1 rst = 1'b1;
      #1;
      check("R1", "acc async clear", int'(acc_out), 0);
      check("R1", "addr async clear", int'(rom_addr), 0);

      // R3: word from address 0 is on the bus but must wait for latency
      @(negedge clk);
      rst = 1'b0;
      @(negedge clk);
      check("R3", "acc stale word held off", int'(acc_out), 0);
      @(negedge clk);
      check("R3", "acc after latency", int'(acc_out), 16'h1234);
      check("R2", "addr after latency", int'(rom_addr), 2);

      report();
      $finish;
   end

endmodule